// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel NOR-style flash. After the host has sent a program or erase command, it hands the poller one request. The request holds the kind of operation, the address to watch and, for a program, the value of bit 7 of the word being written. The poller then issues read cycles on a simple request/acknowledge read port. It compares bit 7 of each returned word against the value that means the operation has finished. It ends with a single-cycle pulse: either done, which comes with the final data word, or timeout.

Bit 7 of the flash can change from its status meaning to true data earlier than the other bits of the same word. A read in which bit 7 first looks finished may therefore carry stale bits elsewhere. The poller always performs one more confirming read at the same address. It returns that second word only if bit 7 still shows completion there. Idle gaps between reads and the maximum number of unsuccessful reads are set with each request.

Top module: `fpoll_top`

## Requirements
- R1: While `busy` is high, `req_valid` is ignored: the address, the expected bit and the limits of the running operation do not change.
- R2: For a program request (`req_erase`=0), every read is issued at `req_addr`, and a read counts as complete when `rd_data[7]` equals `req_stat_bit`.
- R3: For an erase request (`req_erase`=1), every read is issued at `req_addr` (an address inside a sector being erased), and a read counts as complete when `rd_data[7]` is 1.
- R4: After the first complete read, exactly one further read is made. If that read is also complete, `done` pulses and `final_data` is the word of that second read, not the word of the first complete read.
- R5: If the confirming read is not complete, the poller goes back to polling. That read counts as an unsuccessful read.
- R6: Every read that is not complete counts as one miss. The miss that brings the count to `poll_limit` (a limit of 0 acts as 1) ends the operation with a `timeout` pulse, after which no further read is issued.
- R7: After each acknowledged read that does not end the operation, `rd_req` stays low for exactly `gap_len`+1 cycles before the next read is requested.
- R8: `rd_req` rises in the cycle after a request is accepted. It then stays high with `rd_addr` stable until `rd_ack` is seen.
- R9: `done` and `timeout` are single-cycle pulses in the cycle after the final acknowledged read, never both at once. `busy` is low in that same cycle.
- R10: After reset the poller is idle: `busy`, `rd_req`, `done` and `timeout` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, accepted only while idle |
| req_erase | input | 1 | 1 = erase operation, 0 = program operation |
| req_addr | input | AW | Address to poll |
| req_stat_bit | input | 1 | Bit 7 of the programmed word (program only) |
| poll_limit | input | CW | Maximum number of misses |
| gap_len | input | GW | Idle cycles between reads, minus one |
| busy | output | 1 | An operation is in progress |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | DW | Read data (DW is 8 or 16) |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Timeout pulse |
| final_data | output | DW | Word from the confirming read, updated with `done` |

## Verification
The responder model can return a word whose bit 7 already shows completion while its other bits are corrupted. A poller that skips the confirming read, or that latches the first complete word, reports a wrong `final_data`. Other sequences show bit 7 complete and then reverting on the next read. A design that trusts the first complete read would finish early here, and one that does not count the failed confirm as a miss would miss its timeout read. The bench measures the idle run between an acknowledge and the next request for gaps of zero and above, which catches an off-by-one in the gap timer. It also raises a second request in the middle of an operation, so a poller that accepts it shows up as a change of read address.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  // Index of the completion status bit in both 8- and 16-bit bus widths
  localparam int STAT_BIT = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_GAP  = 2'd2
  } fsm_st_t;

endpackage

// File: rtl/fpoll_gap_timer.sv
module fpoll_gap_timer #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] len,
  output logic          expired
);

  logic [GW-1:0] cnt_q;
  logic [GW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = len;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/fpoll_miss_ctr.sv
module fpoll_miss_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          at_limit
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW:0]   cnt_inc;

  // Count after the miss now being judged; one extra bit avoids wrap
  assign cnt_inc  = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign at_limit = (cnt_inc >= {1'b0, limit});

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_inc[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fpoll_seq.sv
module fpoll_seq
  import fpoll_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int CW = 8,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_erase,
  input  logic [AW-1:0] req_addr,
  input  logic          req_stat_bit,
  input  logic [CW-1:0] poll_limit,
  input  logic [GW-1:0] gap_len,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic          timeout,
  output logic [DW-1:0] final_data,
  output logic          gap_load,
  output logic [GW-1:0] gap_val,
  input  logic          gap_expired,
  output logic          miss_clr,
  output logic          miss_inc,
  output logic [CW-1:0] miss_limit,
  input  logic          miss_at_limit
);

  fsm_st_t       st_q, st_d;
  logic          conf_q, conf_d;
  logic          done_q, done_d;
  logic          tmo_q, tmo_d;
  logic [DW-1:0] fin_q, fin_d;
  logic          fin_en;
  logic          cap_en;
  logic [AW-1:0] addr_q;
  logic          exp_q;
  logic [GW-1:0] gap_q;
  logic [CW-1:0] lim_q;
  logic          hit;

  assign hit = (rd_data[STAT_BIT] == exp_q);

  always_comb begin
    st_d     = st_q;
    conf_d   = conf_q;
    done_d   = 1'b0;
    tmo_d    = 1'b0;
    fin_d    = fin_q;
    fin_en   = 1'b0;
    cap_en   = 1'b0;
    gap_load = 1'b0;
    miss_clr = 1'b0;
    miss_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en   = 1'b1;
          miss_clr = 1'b1;
          conf_d   = 1'b0;
          st_d     = ST_READ;
        end
      end
      ST_READ: begin
        if (rd_ack) begin
          if (hit && conf_q) begin
            done_d = 1'b1;
            fin_d  = rd_data;
            fin_en = 1'b1;
            conf_d = 1'b0;
            st_d   = ST_IDLE;
          end else if (hit) begin
            conf_d   = 1'b1;
            gap_load = 1'b1;
            st_d     = ST_GAP;
          end else begin
            conf_d = 1'b0;
            if (miss_at_limit) begin
              tmo_d = 1'b1;
              st_d  = ST_IDLE;
            end else begin
              miss_inc = 1'b1;
              gap_load = 1'b1;
              st_d     = ST_GAP;
            end
          end
        end
      end
      ST_GAP: begin
        if (gap_expired) begin
          st_d = ST_READ;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      conf_q <= 1'b0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      conf_q <= conf_d;
      done_q <= done_d;
      tmo_q  <= tmo_d;
    end
  end

  // Request fields, captured only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      exp_q  <= 1'b0;
      gap_q  <= '0;
      lim_q  <= '0;
    end else if (cap_en) begin
      addr_q <= req_addr;
      exp_q  <= req_erase | req_stat_bit;
      gap_q  <= gap_len;
      lim_q  <= poll_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q <= '0;
    end else if (fin_en) begin
      fin_q <= fin_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign rd_req     = (st_q == ST_READ);
  assign rd_addr    = addr_q;
  assign done       = done_q;
  assign timeout    = tmo_q;
  assign final_data = fin_q;
  assign gap_val    = gap_q;
  assign miss_limit = lim_q;

endmodule

// File: rtl/fpoll_top.sv
module fpoll_top #(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int CW = 8,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_erase,
  input  logic [AW-1:0] req_addr,
  input  logic          req_stat_bit,
  input  logic [CW-1:0] poll_limit,
  input  logic [GW-1:0] gap_len,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic          timeout,
  output logic [DW-1:0] final_data
);

  if ((DW != 8) && (DW != 16)) begin : g_bad_width
    $error("fpoll_top: DW must be 8 or 16");
  end

  logic          gap_load;
  logic [GW-1:0] gap_val;
  logic          gap_expired;
  logic          miss_clr;
  logic          miss_inc;
  logic [CW-1:0] miss_limit;
  logic          miss_at_limit;

  fpoll_seq #(
    .DW(DW), .AW(AW), .CW(CW), .GW(GW)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_erase     (req_erase),
    .req_addr      (req_addr),
    .req_stat_bit  (req_stat_bit),
    .poll_limit    (poll_limit),
    .gap_len       (gap_len),
    .busy          (busy),
    .rd_req        (rd_req),
    .rd_addr       (rd_addr),
    .rd_ack        (rd_ack),
    .rd_data       (rd_data),
    .done          (done),
    .timeout       (timeout),
    .final_data    (final_data),
    .gap_load      (gap_load),
    .gap_val       (gap_val),
    .gap_expired   (gap_expired),
    .miss_clr      (miss_clr),
    .miss_inc      (miss_inc),
    .miss_limit    (miss_limit),
    .miss_at_limit (miss_at_limit)
  );

  fpoll_gap_timer #(.GW(GW)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .len     (gap_val),
    .expired (gap_expired)
  );

  fpoll_miss_ctr #(.CW(CW)) u_miss (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (miss_clr),
    .inc      (miss_inc),
    .limit    (miss_limit),
    .at_limit (miss_at_limit)
  );

endmodule

// File: rtl/fpoll_chk.sv
module fpoll_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          done,
  input logic          timeout
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9
  AST_TMO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);  // R9
  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));  // R9
  AST_OUTCOME_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> ($past(rd_ack && rd_req) && !busy));  // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));  // R8
  AST_START_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> (busy && rd_req));  // R8
  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_addr));  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);  // R6

endmodule

bind fpoll_top fpoll_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_ack    (rd_ack),
  .done      (done),
  .timeout   (timeout)
);

// File: tb/sim_fpoll_top.sv
module sim_fpoll_top;

  localparam int CLK_NS = 10;
  localparam int DW = 16;
  localparam int AW = 20;
  localparam int CW = 8;
  localparam int GW = 4;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_erase;
  logic [AW-1:0] req_addr;
  logic          req_stat_bit;
  logic [CW-1:0] poll_limit;
  logic [GW-1:0] gap_len;
  logic          busy;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack;
  logic [DW-1:0] rd_data;
  logic          done;
  logic          timeout;
  logic [DW-1:0] final_data;

  fpoll_top #(.DW(DW), .AW(AW), .CW(CW), .GW(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_stat_bit(req_stat_bit), .poll_limit(poll_limit),
    .gap_len(gap_len), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .done(done), .timeout(timeout),
    .final_data(final_data)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  // Scenario state: 0 = incomplete, 1 = complete bit 7 with corrupt rest, 2 = true word
  int            pat [64];
  logic [DW-1:0] resp [64];
  logic [AW-1:0] cur_addr;
  logic          exp_bit;
  logic [DW-1:0] true_word;
  int            cur_gap;
  int            lat_max;
  int            n_reads;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] make_word(input int code, input logic eb, input logic [DW-1:0] tw);
    logic [DW-1:0] w;
    w = DW'($urandom);
    if (code == 0) begin
      w[7] = ~eb;
    end else if (code == 1) begin
      w = tw ^ (DW'($urandom) | DW'(1));
      w[7] = eb;
    end else begin
      w = tw;
    end
    return w;
  endfunction

  // Expected outcome from the requirements: R4, R5, R6
  task automatic predict(input int mx, output bit is_done, output int nreads);
    int misses = 0;
    bit conf = 0;
    int lim;
    lim = (mx == 0) ? 1 : mx;
    is_done = 0;
    nreads = 64;
    for (int i = 0; i < 64; i++) begin
      if (pat[i] != 0 && conf) begin
        is_done = 1; nreads = i + 1; return;
      end else if (pat[i] != 0) begin
        conf = 1;
      end else begin
        conf = 0;
        misses++;
        if (misses >= lim) begin
          nreads = i + 1; return;
        end
      end
    end
  endtask

  task automatic set_pat(input int misses, input int mode, input int tail);
    int k;
    for (int i = 0; i < 64; i++) pat[i] = tail;
    for (int i = 0; i < misses && i < 56; i++) pat[i] = 0;
    k = (misses < 56) ? misses : 56;
    if (mode == 0) begin pat[k] = 2; pat[k+1] = 2; end
    else if (mode == 1) begin pat[k] = 1; pat[k+1] = 2; end
    else if (mode == 2) begin pat[k] = 2; pat[k+1] = 0; pat[k+2] = 1; pat[k+3] = 2; end
  endtask

  // Flash responder and read-port monitor (R1, R7, R8)
  initial begin : responder
    bit after_ack = 0;
    bit in_read = 0;
    bit prev_busy = 0;
    int gcnt = 0;
    int wcnt = 0;
    int lat = 0;
    rd_ack = 1'b0;
    rd_data = '0;
    n_reads = 0;
    forever begin
      @(negedge clk);
      if (busy && !prev_busy) begin
        n_reads = 0;
        after_ack = 0;
        in_read = 0;
      end
      if (rd_ack) begin
        rd_ack = 1'b0;
        after_ack = 1;
        gcnt = 1;
        in_read = 0;
      end else if (rd_req) begin
        if (after_ack) begin
          chk(gcnt == cur_gap + 1, "R7 idle cycles between reads", gcnt, cur_gap + 1);
          after_ack = 0;
        end
        chk(rd_addr == cur_addr, "R1 R8 read address", 32'(rd_addr), 32'(cur_addr));
        if (!in_read) begin
          in_read = 1;
          wcnt = 0;
          lat = $urandom_range(0, lat_max);
        end
        if (wcnt == lat) begin
          if (n_reads < 64) begin
            resp[n_reads] = make_word(pat[n_reads], exp_bit, true_word);
            rd_data = resp[n_reads];
          end
          rd_ack = 1'b1;
          n_reads++;
        end else begin
          wcnt++;
        end
      end else if (after_ack) begin
        gcnt++;
      end
      prev_busy = busy;
    end
  end

  task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int mx, input int gp, input int lat, input bit inject, input string tag);
    bit pdone;
    int pn;
    int w;
    int nr;
    cur_addr  = a;
    exp_bit   = er ? 1'b1 : d[7];
    true_word = er ? '1 : d;
    cur_gap   = gp;
    lat_max   = lat;
    predict(mx, pdone, pn);
    req_valid    = 1'b1;
    req_erase    = er;
    req_addr     = a;
    req_stat_bit = d[7];
    poll_limit   = CW'(mx);
    gap_len      = GW'(gp);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rd_req && busy, "R8 read requested after accept", {rd_req, busy}, 2'b11);
    if (inject) begin
      repeat (2) @(negedge clk);
      req_valid    = 1'b1;
      req_erase    = ~er;
      req_addr     = ~a;
      req_stat_bit = ~d[7];
      poll_limit   = CW'(1);
      gap_len      = GW'(0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (!(done || timeout) && w < 3000) begin
      @(negedge clk);
      w++;
    end
    chk(done == pdone && timeout == !pdone, {tag, " outcome"}, {done, timeout}, {pdone, !pdone});
    chk(n_reads == pn, {tag, " read count"}, n_reads, pn);
    if (pdone && pn > 0 && pn <= 64)
      chk(final_data == resp[pn-1], "R4 final word from confirming read", final_data, resp[pn-1]);
    chk(!busy, "R9 idle with outcome pulse", busy, 0);
    nr = n_reads;
    @(negedge clk);
    chk(!done && !timeout, "R9 single-cycle outcome", {done, timeout}, 0);
    repeat (4) @(negedge clk);
    chk(n_reads == nr && !rd_req, "R6 no reads after finish", n_reads, nr);
  endtask

  initial begin : watchdog
    #(CLK_NS * 150000);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_valid = 1'b0; req_erase = 1'b0; req_addr = '0; req_stat_bit = 1'b0;
    poll_limit = '0; gap_len = '0;
    cur_addr = '0; exp_bit = 1'b0; true_word = '0; cur_gap = 0; lat_max = 0;
    set_pat(0, 0, 2);
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !done && !timeout, "R10 reset state", {busy, rd_req, done, timeout}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req && !done && !timeout, "R10 idle after reset", {busy, rd_req, done, timeout}, 0);

    // Directed corner cases
    set_pat(3, 0, 2); run_op(1'b0, 20'h01234, 16'h5A00, 8, 1, 1, 1'b0, "R2 program bit7=0");
    set_pat(2, 0, 2); run_op(1'b0, 20'h0ABCD, 16'hC3A5, 8, 0, 0, 1'b0, "R2 program bit7=1");
    set_pat(4, 0, 2); run_op(1'b1, 20'h40000, 16'h0000, 8, 2, 2, 1'b0, "R3 erase");
    set_pat(1, 1, 2); run_op(1'b0, 20'h00F00, 16'h1234, 8, 0, 1, 1'b0, "R4 corrupt first complete");
    set_pat(0, 1, 2); run_op(1'b1, 20'h7FFFF, 16'h0000, 4, 3, 0, 1'b0, "R4 erase corrupt first");
    set_pat(1, 2, 2); run_op(1'b0, 20'h00011, 16'h80FF, 8, 1, 1, 1'b0, "R5 confirm fails");
    set_pat(1, 2, 2); run_op(1'b1, 20'h00022, 16'h0000, 2, 0, 0, 1'b0, "R5 R6 failed confirm hits limit");
    set_pat(64, 3, 0); run_op(1'b0, 20'h00033, 16'h00AA, 5, 1, 1, 1'b0, "R6 timeout limit 5");
    set_pat(64, 3, 0); run_op(1'b1, 20'h00044, 16'h0000, 0, 0, 0, 1'b0, "R6 limit zero");
    set_pat(0, 0, 2); run_op(1'b0, 20'h00055, 16'h7F7F, 1, 15, 0, 1'b0, "R7 long gap");
    set_pat(6, 0, 2); run_op(1'b0, 20'h12345, 16'h0080, 10, 2, 1, 1'b1, "R1 request while busy");

    // Constrained random operations
    for (int n = 0; n < 40; n++) begin
      bit er;
      er = 1'($urandom);
      set_pat($urandom_range(0, 7), $urandom_range(0, 2), (($urandom % 4) == 0) ? 0 : 2);
      run_op(er, AW'($urandom), DW'($urandom), $urandom_range(1, 6), $urandom_range(0, 4),
             $urandom_range(0, 2), 1'b0, er ? "R3 random erase" : "R2 random program");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule